// File: doc/BRIEF.md
# Overcurrent Fault Integrator with Hiccup Restart

This block is the digital side of short-circuit protection for a switching converter. An external comparator raises a one-bit overcurrent flag, and a one-clock strobe marks the start of each PWM period. Any clock in which the flag is high removes the high-side gate enable at once. The enable stays off until the next period begins. When a period closes, the block weighs it: a period that saw the flag adds one to a fault tally, and a clean period takes one away. The tally never drops below zero.

When the tally reaches the fault limit (seven by default), the block enters hiccup. Both gate enables are held low and a fault flag is raised for a fixed number of soft-start periods (seven by default). The soft-start period is a parameter counted in clocks. Strobes and overcurrent flags have no effect during hiccup. When the time-out expires, the fault flag drops, a one-clock restart pulse asks the soft-start generator for a fresh ramp, and the tally starts again from zero.

Top module: `ocp_hiccup_ctrl`

## Requirements
- R1: In any clock where `oc_flag` is 1, `hs_en` is 0 in that same clock. `hs_en` then stays 0 for every later clock of that PWM period, and returns to 1 in the clock after the next `cycle_start` edge if no fault is active.
- R2: At a `cycle_start` edge outside hiccup, a closing period that saw `oc_flag` (including in the strobe clock itself) raises the tally by one, visible in the next clock.
- R3: At a `cycle_start` edge outside hiccup, a clean closing period lowers the tally by one.
- R4: When the tally reaches FAULT_LIMIT (default 7), `fault` is 1 from the clock after that closing strobe, and `hs_en` is 0.
- R5: While `fault` is 1, both `hs_en` and `ls_en` are 0.
- R6: `fault` stays 1 for exactly HICCUP_PERIODS × SS_CLKS clocks (default 7 × SS_CLKS).
- R7: `restart` is 1 for exactly one clock: the first clock in which `fault` is 0 again. `hs_en` and `ls_en` are 1 in that clock.
- R8: A clean period closed while the tally is zero leaves it at zero. The tally does not wrap around.
- R9: Reset and the restart both clear the tally to zero.
- R10: During hiccup, `cycle_start` and `oc_flag` change neither the tally nor the length of the time-out.
- R11: After reset, `hs_en` = 1, `ls_en` = 1, `fault` = 0 and `restart` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_start | input | 1 | One-clock strobe at the start of each PWM period |
| oc_flag | input | 1 | Overcurrent comparator output, 1 = overcurrent |
| hs_en | output | 1 | High-side gate drive enable |
| ls_en | output | 1 | Low-side gate drive enable |
| fault | output | 1 | 1 while the hiccup time-out runs |
| restart | output | 1 | One-clock request for a new soft-start |

## Verification
The high-side cut is combinational, so the bench samples `hs_en` 1 ns after it drives `oc_flag` on a falling edge. It samples again one clock later to see that the cut is held. The tally update and the fault flag are registered at the strobe edge. The scoreboard therefore pops each expected item at the falling edge that follows that strobe edge, and compares `fault`, `hs_en` and `ls_en` against it there. A separate monitor measures the length of each fault run at falling edges and expects `restart` in the first low clock, which is the same clock the flag falls.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

    // Counter width able to hold values 0 .. n-1, at least one bit.
    function automatic int cnt_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ocp_cycle_latch.sv
// Remembers whether the current PWM period has seen an overcurrent flag.
module ocp_cycle_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic cycle_start,
    input  logic oc_flag,
    input  logic hold_clear,
    output logic seen,
    output logic period_hit
);
    typedef struct packed {
        logic seen;
    } lat_s;

    lat_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_clear || cycle_start) begin
            st_d.seen = 1'b0;
        end else if (oc_flag) begin
            st_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign seen       = st_q.seen;
    // A flag raised in the strobe clock still belongs to the closing period.
    assign period_hit = st_q.seen | oc_flag;
endmodule

// File: rtl/ocp_fault_integrator.sv
// Up/down tally of overcurrent periods, saturating at zero and at the limit.
module ocp_fault_integrator #(
    parameter int FAULT_LIMIT = 7
) (
    input  logic                                          clk,
    input  logic                                          rst_n,
    input  logic                                          close_period,
    input  logic                                          period_hit,
    input  logic                                          clear,
    output logic [ocp_pkg::cnt_width(FAULT_LIMIT+1)-1:0]  tally,
    output logic                                          trip
);
    localparam int CW = ocp_pkg::cnt_width(FAULT_LIMIT + 1);
    localparam logic [CW-1:0] LIM     = CW'(FAULT_LIMIT);
    localparam logic [CW-1:0] LIM_M1  = CW'(FAULT_LIMIT - 1);
    localparam logic [CW-1:0] ONE     = CW'(1);

    typedef struct packed {
        logic [CW-1:0] cnt;
    } int_s;

    int_s st_d, st_q;
    logic trip_w;

    always_comb begin
        st_d   = st_q;
        trip_w = close_period && period_hit && (st_q.cnt == LIM_M1);
        if (clear) begin
            st_d.cnt = '0;
        end else if (close_period) begin
            if (period_hit) begin
                if (st_q.cnt != LIM) begin
                    st_d.cnt = st_q.cnt + ONE;
                end
            end else if (st_q.cnt != '0) begin
                st_d.cnt = st_q.cnt - ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tally = st_q.cnt;
    assign trip  = trip_w;
endmodule

// File: rtl/ocp_hiccup_timer.sv
// Holds the fault state for a number of soft-start periods, then pulses restart.
module ocp_hiccup_timer #(
    parameter int SS_CLKS        = 64,
    parameter int HICCUP_PERIODS = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trip,
    output logic active,
    output logic done,
    output logic restart
);
    localparam int SW = ocp_pkg::cnt_width(SS_CLKS);
    localparam int PW = ocp_pkg::cnt_width(HICCUP_PERIODS);
    localparam logic [SW-1:0] SS_LAST  = SW'(SS_CLKS - 1);
    localparam logic [PW-1:0] PER_LAST = PW'(HICCUP_PERIODS - 1);

    typedef struct packed {
        logic          active;
        logic          restart;
        logic [SW-1:0] ss_cnt;
        logic [PW-1:0] per_cnt;
    } tmr_s;

    tmr_s st_d, st_q;
    logic ss_last, per_last, done_w;

    always_comb begin
        st_d         = st_q;
        ss_last      = (st_q.ss_cnt == SS_LAST);
        per_last     = (st_q.per_cnt == PER_LAST);
        done_w       = st_q.active && ss_last && per_last;
        st_d.restart = done_w;
        if (trip && !st_q.active) begin
            st_d.active  = 1'b1;
            st_d.ss_cnt  = '0;
            st_d.per_cnt = '0;
        end else if (st_q.active) begin
            if (done_w) begin
                st_d.active  = 1'b0;
                st_d.ss_cnt  = '0;
                st_d.per_cnt = '0;
            end else if (ss_last) begin
                st_d.ss_cnt  = '0;
                st_d.per_cnt = st_q.per_cnt + PW'(1);
            end else begin
                st_d.ss_cnt  = st_q.ss_cnt + SW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active  = st_q.active;
    assign done    = done_w;
    assign restart = st_q.restart;
endmodule

// File: rtl/ocp_hiccup_ctrl.sv
// Top: overcurrent period integrator with hiccup time-out and auto restart.
module ocp_hiccup_ctrl #(
    parameter int SS_CLKS        = 64,
    parameter int HICCUP_PERIODS = 7,
    parameter int FAULT_LIMIT    = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cycle_start,
    input  logic oc_flag,
    output logic hs_en,
    output logic ls_en,
    output logic fault,
    output logic restart
);
    localparam int CW = ocp_pkg::cnt_width(FAULT_LIMIT + 1);

    logic          oc_seen;
    logic          period_hit;
    logic          close_period;
    logic          trip;
    logic          hic_active;
    logic          hic_done;
    logic          hic_restart;
    logic [CW-1:0] fault_cnt;

    assign close_period = cycle_start && !hic_active;

    ocp_cycle_latch u_latch (
        .clk         (clk),
        .rst_n       (rst_n),
        .cycle_start (cycle_start),
        .oc_flag     (oc_flag),
        .hold_clear  (hic_active),
        .seen        (oc_seen),
        .period_hit  (period_hit)
    );

    ocp_fault_integrator #(
        .FAULT_LIMIT (FAULT_LIMIT)
    ) u_integ (
        .clk          (clk),
        .rst_n        (rst_n),
        .close_period (close_period),
        .period_hit   (period_hit),
        .clear        (hic_done),
        .tally        (fault_cnt),
        .trip         (trip)
    );

    ocp_hiccup_timer #(
        .SS_CLKS        (SS_CLKS),
        .HICCUP_PERIODS (HICCUP_PERIODS)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .trip    (trip),
        .active  (hic_active),
        .done    (hic_done),
        .restart (hic_restart)
    );

    // High side drops in the very clock the comparator fires.
    assign hs_en   = !hic_active && !oc_seen && !oc_flag;
    assign ls_en   = !hic_active;
    assign fault   = hic_active;
    assign restart = hic_restart;
endmodule

// File: rtl/ocp_hiccup_ctrl_chk.sv
module ocp_hiccup_ctrl_chk #(
    parameter int SS_CLKS        = 64,
    parameter int HICCUP_PERIODS = 7,
    parameter int FAULT_LIMIT    = 7
) (
    input logic                                         clk,
    input logic                                         rst_n,
    input logic                                         cycle_start,
    input logic                                         oc_flag,
    input logic                                         hs_en,
    input logic                                         ls_en,
    input logic                                         fault,
    input logic                                         restart,
    input logic                                         seen,
    input logic [ocp_pkg::cnt_width(FAULT_LIMIT+1)-1:0] cnt
);
    localparam int TOTAL = SS_CLKS * HICCUP_PERIODS;
    localparam int DW    = ocp_pkg::cnt_width(TOTAL + 2);

    logic [DW-1:0] dur_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      dur_q <= '0;
        else if (fault)  dur_q <= dur_q + DW'(1);
        else             dur_q <= '0;
    end

    AST_HS_CUT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (oc_flag && !cycle_start && !fault) |=> !hs_en); // R1
    AST_CNT_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && !fault && (seen || oc_flag) && cnt != FAULT_LIMIT)
        |=> (cnt == $past(cnt) + 1'b1)); // R2
    AST_CNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && !fault && !seen && !oc_flag && cnt != 0)
        |=> (cnt + 1'b1 == $past(cnt))); // R3
    AST_TRIP_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == FAULT_LIMIT) |-> (fault && !hs_en)); // R4
    AST_BOTH_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> (!hs_en && !ls_en)); // R5
    AST_HICCUP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> (dur_q == DW'(TOTAL))); // R6
    AST_RESTART_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fault) |-> (restart && hs_en == !oc_flag && ls_en)); // R7
    AST_RESTART_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !restart); // R7
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && !fault && !seen && !oc_flag && cnt == 0) |=> (cnt == 0)); // R8
    AST_CLEAR_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |-> (cnt == 0)); // R9
    AST_FROZEN_IN_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (fault && !$fell(fault) && $past(fault)) |-> $stable(cnt)); // R10
endmodule

bind ocp_hiccup_ctrl ocp_hiccup_ctrl_chk #(
    .SS_CLKS        (SS_CLKS),
    .HICCUP_PERIODS (HICCUP_PERIODS),
    .FAULT_LIMIT    (FAULT_LIMIT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cycle_start (cycle_start),
    .oc_flag     (oc_flag),
    .hs_en       (hs_en),
    .ls_en       (ls_en),
    .fault       (fault),
    .restart     (restart),
    .seen        (oc_seen),
    .cnt         (fault_cnt)
);

// File: tb/ocp_hiccup_ctrl_tb_top.sv
`timescale 1ns/1ps
module ocp_hiccup_ctrl_tb_top;
    localparam int SS   = 8;
    localparam int HP   = 7;
    localparam int LIM  = 7;
    localparam int HLEN = SS * HP;
    localparam int CYC  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cycle_start = 1'b0;
    logic oc_flag = 1'b0;
    logic hs_en, ls_en, fault, restart;

    always #4 clk = ~clk;

    ocp_hiccup_ctrl #(.SS_CLKS(SS), .HICCUP_PERIODS(HP), .FAULT_LIMIT(LIM)) dut_i (
        .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start), .oc_flag(oc_flag),
        .hs_en(hs_en), .ls_en(ls_en), .fault(fault), .restart(restart)
    );

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    // Reference model of the tally and the fault state.
    int m_cnt = 0;
    bit m_fault = 1'b0;
    bit pend = 1'b0;
    bit exp_q[$];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Driver: one PWM period; oc pulse at clock index oc_at (2..CYC-1), -1 for none.
    task automatic run_cycle(input int oc_at);
        for (int i = 0; i < CYC; i++) begin
            cycle_start = (i == 0);
            oc_flag     = (i == oc_at);
            if (i == 0) begin
                if (!m_fault) begin
                    if (pend) begin
                        m_cnt++;
                        if (m_cnt >= LIM) m_fault = 1'b1;
                    end else if (m_cnt > 0) begin
                        m_cnt--;
                    end
                end
                pend = 1'b0;
                exp_q.push_back(m_fault);
            end
            #1;
            if (i == oc_at && !m_fault)
                check(hs_en == 1'b0, "R1", "hs_en in oc clock", hs_en, 0);
            if (i == oc_at + 1 && oc_at >= 0 && !m_fault)
                check(hs_en == 1'b0, "R1", "hs_en held after oc", hs_en, 0);
            if (i == oc_at && !m_fault) pend = 1'b1;
            @(negedge clk);
        end
        cycle_start = 1'b0;
        oc_flag     = 1'b0;
    endtask

    task automatic wait_restart();
        while (fault) @(negedge clk);
        #1;
        check(hs_en == 1'b1 && ls_en == 1'b1, "R7", "enables back after hiccup",
              {hs_en, ls_en}, 3);
        m_fault = 1'b0;
        m_cnt   = 0;
        pend    = 1'b0;
        #1;
    endtask

    // Monitor: pops the expected fault state one clock after each strobe edge.
    always @(posedge clk) begin
        if (rst_n && cycle_start) begin
            @(negedge clk);
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "scoreboard underrun", 0, 1);
            end else begin
                bit e;
                e = exp_q.pop_front();
                check(fault == e, "R4", "fault after strobe", fault, e);
                check(hs_en == !e, "R1", "hs_en after strobe", hs_en, !e);
                check(ls_en == !e, "R5", "ls_en after strobe", ls_en, !e);
            end
        end
    end

    // Hiccup length, enable and restart monitor.
    int run_len = 0;
    int bad_en = 0;
    bit prev_fault = 1'b0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (fault) begin
                run_len++;
                if (hs_en || ls_en) bad_en++;
            end else if (prev_fault) begin
                check(run_len == HLEN, "R6", "hiccup length", run_len, HLEN);
                check(bad_en == 0, "R5", "enables during hiccup", bad_en, 0);
                check(restart == 1'b1, "R7", "restart in first clear clock", restart, 1);
                run_len = 0;
                bad_en  = 0;
            end else if (restart) begin
                check(1'b0, "R7", "restart outside first clear clock", restart, 0);
            end
            prev_fault = fault;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int pat[9];
        pat = '{-1, 3, -1, 2, 5, 2, 2, -1, -1};
        repeat (3) @(negedge clk);
        #1;
        check(hs_en == 1 && ls_en == 1, "R11", "enables in reset state", {hs_en, ls_en}, 3);
        check(fault == 0 && restart == 0, "R11", "fault/restart in reset state",
              {fault, restart}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(hs_en == 1 && fault == 0, "R11", "state after reset release",
              {hs_en, fault}, 2);
        @(negedge clk);

        // R1 cut and hold, R2 up then R3 down.
        run_cycle(-1);
        run_cycle(3);
        run_cycle(-1);
        // R8: extra clean periods at zero must not wrap to the limit.
        run_cycle(-1);
        run_cycle(-1);
        run_cycle(-1);
        // R2/R4: seven overcurrent periods, tripping on the closing strobe.
        for (int k = 0; k < LIM; k++) run_cycle(2);
        // R10: strobes and oc flags while in hiccup.
        run_cycle(4);
        run_cycle(3);
        run_cycle(2);
        check(fault == 1'b1, "R10", "fault held despite strobes", fault, 1);
        wait_restart();
        // R9: tally cleared by restart; six oc periods must not trip.
        for (int k = 0; k < LIM - 1; k++) run_cycle(2);
        run_cycle(-1);
        check(fault == 1'b0, "R9", "no trip after six periods post restart", fault, 0);
        // Mixed up/down pattern until trip (R2, R3, R4).
        foreach (pat[k]) begin
            if (!m_fault) run_cycle(pat[k]);
        end
        check(m_fault == 1'b1 && fault == 1'b1, "R4", "mixed pattern trips", fault, 1);
        wait_restart();
        run_cycle(-1);
        run_cycle(-1);
        repeat (4) @(negedge clk);
        check(exp_q.size() == 0, "R2", "scoreboard drained", exp_q.size(), 0);
        done_flag = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule